// File: doc/BRIEF.md
# Word-24 and End-of-Scan Decoder

This block watches two free-running position counters of a framed serial stream: a 5-bit word counter and a bit-position counter that walks through each word. When the bit counter reaches its last position, the block raises a second-level end-of-scan pulse on the next clock. It then raises a third-level pulse exactly one clock after that. The second level is the enable of a word decoder. At each end of scan it loads whether the word just finished was word 23 (binary 10111). The resulting flag therefore marks the whole of word 24.

Three more outputs come with the flag. A bit-0 flag is high only in the first bit slot of word 24. A one-cycle strobe combines the word-23 match with the second-level end-of-scan, so it marks the moment word 24 begins. The two staggered end-of-scan levels go out to downstream logic, which uses them as ordered scan boundaries.

Top module: `w24_eos_decoder`

## Requirements
- R1: While rst_n is low, all five outputs are 0.
- R2: eos_lvl2 is 1 in the clock cycle after an edge at which bit_cnt equalled SCAN_LAST (default 15), and 0 after any edge at which bit_cnt held another value.
- R3: eos_lvl3 is a copy of eos_lvl2 delayed by exactly one clock.
- R4: At an edge where eos_lvl2 is 1, w24_flag loads 1 if word_cnt was 23 at the previous edge, and loads 0 otherwise.
- R5: Only the exact 5-bit word count 10111 (23) counts as a match. Values that share some of its set bits, such as 7, 15, 19, 21, 22 and 31, never raise w24_flag or w24_eos_strobe.
- R6: w24_eos_strobe is 1 exactly during an eos_lvl2 cycle whose scan ended with word_cnt equal to 23, and is 0 in all other cycles.
- R7: w24_bit0 is 1 in the cycle after an edge at which bit_cnt was 0 and w24_flag becomes or stays 1. It is 0 whenever w24_flag is 0.
- R8: While eos_lvl2 is 0, changes on word_cnt have no effect on w24_flag, which holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| word_cnt | input | WORD_W (5) | Current word number within the frame |
| bit_cnt | input | BIT_W (4) | Current bit position within the word |
| w24_flag | output | 1 | High for the duration of word 24 |
| w24_bit0 | output | 1 | High in the bit-0 slot of word 24 |
| eos_lvl2 | output | 1 | Second-level end-of-scan pulse |
| eos_lvl3 | output | 1 | Third-level end-of-scan pulse, one clock after eos_lvl2 |
| w24_eos_strobe | output | 1 | Word-23 match combined with eos_lvl2 |

## Verification
The properties assume that bit_cnt and word_cnt are stable across each rising edge. They do not assume that the counters follow a real counting order, because the decoder only compares the sampled values. The bench drives both counters on the falling edge and reads the outputs one time unit after the rising edge. It places counter values directly rather than running whole frames: terminal positions, the target word, near-miss words and bit-0 slots, in the order the checks need.

// File: rtl/w24_pkg.sv
package w24_pkg;
   localparam int unsigned WORD_W_DEF     = 5;
   localparam int unsigned BIT_W_DEF      = 4;
   localparam int unsigned SCAN_LAST_DEF  = 15;
   localparam int unsigned WORD_MATCH_DEF = 23;
   localparam int unsigned N_LEVELS_DEF   = 2;

   typedef enum logic {
      STROBE_COMB = 1'b0,
      STROBE_REG  = 1'b1
   } strobe_mode_e;
endpackage

// File: rtl/w24_scan_stagger.sv
module w24_scan_stagger #(
   parameter int unsigned BIT_W     = w24_pkg::BIT_W_DEF,
   parameter int unsigned SCAN_LAST = w24_pkg::SCAN_LAST_DEF,
   parameter int unsigned N_LEVELS  = w24_pkg::N_LEVELS_DEF
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [BIT_W-1:0]    bit_cnt,
   output logic [N_LEVELS-1:0] eos_lv
);
   localparam logic [BIT_W-1:0] TERM = BIT_W'(SCAN_LAST);

   if (SCAN_LAST >= (1 << BIT_W)) begin : g_bad_term
      $error("SCAN_LAST does not fit in BIT_W bits");
   end
   if (N_LEVELS < 2) begin : g_bad_levels
      $error("N_LEVELS must be at least 2");
   end

   logic term_hit;
   assign term_hit = (bit_cnt == TERM);

   for (genvar i = 0; i < N_LEVELS; i++) begin : g_lvl
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) eos_lv[i] <= 1'b0;
            else        eos_lv[i] <= term_hit;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) eos_lv[i] <= 1'b0;
            else        eos_lv[i] <= eos_lv[i-1];
         end
         // R3: each level trails the one before it by a single clock
         p_stagger_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
            eos_lv[i-1] |=> eos_lv[i]);
         p_stagger_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !eos_lv[i-1] |=> !eos_lv[i]);
      end
   end

   // R2: first level follows the terminal bit position by one clock
   p_eos_after_term_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_cnt == TERM) |=> eos_lv[0]);
   p_no_eos_early_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_cnt != TERM) |=> !eos_lv[0]);
endmodule

// File: rtl/w24_word_match.sv
module w24_word_match #(
   parameter int unsigned WORD_W     = w24_pkg::WORD_W_DEF,
   parameter int unsigned BIT_W      = w24_pkg::BIT_W_DEF,
   parameter int unsigned WORD_MATCH = w24_pkg::WORD_MATCH_DEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] word_cnt,
   input  logic [BIT_W-1:0]  bit_cnt,
   input  logic              eos_en,
   output logic              match_q,
   output logic              w24_q,
   output logic              b0_q
);
   localparam logic [WORD_W-1:0] TARGET = WORD_W'(WORD_MATCH);

   if (WORD_MATCH >= (1 << WORD_W)) begin : g_bad_match
      $error("WORD_MATCH does not fit in WORD_W bits");
   end

   logic w24_nxt;
   always_comb begin
      w24_nxt = w24_q;
      if (eos_en) w24_nxt = match_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         match_q <= 1'b0;
         w24_q   <= 1'b0;
         b0_q    <= 1'b0;
      end else begin
         match_q <= (word_cnt == TARGET);
         w24_q   <= w24_nxt;
         b0_q    <= w24_nxt & (bit_cnt == '0);
      end
   end

   // R8: flag frozen between end-of-scan enables
   p_w24_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !eos_en |=> $stable(w24_q));
   // R4: enable loads the match captured with the terminal bit
   p_w24_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      eos_en |=> (w24_q == $past(match_q)));
   // R7: bit-0 flag only inside word 24
   p_b0_in_w24_r7: assert property (@(posedge clk) disable iff (!rst_n)
      b0_q |-> w24_q);
endmodule

// File: rtl/w24_eos_decoder.sv
module w24_eos_decoder #(
   parameter int unsigned WORD_W     = w24_pkg::WORD_W_DEF,
   parameter int unsigned BIT_W      = w24_pkg::BIT_W_DEF,
   parameter int unsigned SCAN_LAST  = w24_pkg::SCAN_LAST_DEF,
   parameter int unsigned WORD_MATCH = w24_pkg::WORD_MATCH_DEF,
   parameter int unsigned N_LEVELS   = w24_pkg::N_LEVELS_DEF,
   parameter bit          STROBE_MODE = w24_pkg::STROBE_COMB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] word_cnt,
   input  logic [BIT_W-1:0]  bit_cnt,
   output logic              w24_flag,
   output logic              w24_bit0,
   output logic              eos_lvl2,
   output logic              eos_lvl3,
   output logic              w24_eos_strobe
);
   logic [N_LEVELS-1:0] eos_lv;
   logic                match_q;

   w24_scan_stagger #(
      .BIT_W     (BIT_W),
      .SCAN_LAST (SCAN_LAST),
      .N_LEVELS  (N_LEVELS)
   ) u_stagger (
      .clk     (clk),
      .rst_n   (rst_n),
      .bit_cnt (bit_cnt),
      .eos_lv  (eos_lv)
   );

   w24_word_match #(
      .WORD_W     (WORD_W),
      .BIT_W      (BIT_W),
      .WORD_MATCH (WORD_MATCH)
   ) u_match (
      .clk      (clk),
      .rst_n    (rst_n),
      .word_cnt (word_cnt),
      .bit_cnt  (bit_cnt),
      .eos_en   (eos_lv[0]),
      .match_q  (match_q),
      .w24_q    (w24_flag),
      .b0_q     (w24_bit0)
   );

   assign eos_lvl2 = eos_lv[0];
   assign eos_lvl3 = eos_lv[1];

   if (STROBE_MODE == w24_pkg::STROBE_COMB) begin : g_strobe_comb
      assign w24_eos_strobe = eos_lv[0] & match_q;
      // R6: strobe confined to second-level end-of-scan cycles
      p_strobe_in_eos_r6: assert property (@(posedge clk) disable iff (!rst_n)
         w24_eos_strobe |-> eos_lvl2);
      p_strobe_sets_w24_r6: assert property (@(posedge clk) disable iff (!rst_n)
         w24_eos_strobe |=> w24_flag);
   end else begin : g_strobe_reg
      logic strobe_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) strobe_q <= 1'b0;
         else        strobe_q <= eos_lv[0] & match_q;
      end
      assign w24_eos_strobe = strobe_q;
      // R6: registered strobe aligns with the third level
      p_strobe_in_eos3_r6: assert property (@(posedge clk) disable iff (!rst_n)
         w24_eos_strobe |-> eos_lvl3);
   end
endmodule

// File: tb/w24_eos_decoder_bench.sv
module w24_eos_decoder_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] word_cnt = '0;
   logic [3:0] bit_cnt = '0;
   logic       w24_flag, w24_bit0, eos_lvl2, eos_lvl3, w24_eos_strobe;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   w24_eos_decoder u_w24_eos_decoder (
      .clk            (clk),
      .rst_n          (rst_n),
      .word_cnt       (word_cnt),
      .bit_cnt        (bit_cnt),
      .w24_flag       (w24_flag),
      .w24_bit0       (w24_bit0),
      .eos_lvl2       (eos_lvl2),
      .eos_lvl3       (eos_lvl3),
      .w24_eos_strobe (w24_eos_strobe)
   );

   task automatic chk(input string req, input string nm, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%b expected=%b at %0t", req, nm, act, exp, $time);
      end
   endtask

   task automatic drive(input logic [4:0] w, input logic [3:0] b);
      @(negedge clk);
      word_cnt = w;
      bit_cnt  = b;
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk_all_zero(input string req);
      chk(req, "w24_flag", w24_flag, 1'b0);
      chk(req, "w24_bit0", w24_bit0, 1'b0);
      chk(req, "eos_lvl2", eos_lvl2, 1'b0);
      chk(req, "eos_lvl3", eos_lvl3, 1'b0);
      chk(req, "strobe", w24_eos_strobe, 1'b0);
   endtask

   // R1: outputs clear under reset
   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) tick();
      chk_all_zero("R1");
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // R2, R3: staggered end-of-scan levels
   task automatic t_stagger();
      drive(5'd5, 4'd14);
      tick();
      chk("R2", "eos_lvl2 before terminal", eos_lvl2, 1'b0);
      drive(5'd5, 4'd15);
      tick();
      chk("R2", "eos_lvl2 after terminal", eos_lvl2, 1'b1);
      chk("R3", "eos_lvl3 same cycle", eos_lvl3, 1'b0);
      chk("R6", "strobe on non-23 word", w24_eos_strobe, 1'b0);
      drive(5'd6, 4'd3);
      tick();
      chk("R2", "eos_lvl2 drops", eos_lvl2, 1'b0);
      chk("R3", "eos_lvl3 one clock later", eos_lvl3, 1'b1);
      tick();
      chk("R3", "eos_lvl3 drops", eos_lvl3, 1'b0);
   endtask

   // R4, R6, R7: entering word 24
   task automatic t_enter_w24();
      drive(5'd23, 4'd15);
      tick();
      chk("R6", "strobe at eos of word 23", w24_eos_strobe, 1'b1);
      chk("R4", "w24 not yet set", w24_flag, 1'b0);
      drive(5'd24, 4'd0);
      tick();
      chk("R4", "w24 set", w24_flag, 1'b1);
      chk("R7", "bit0 in first slot", w24_bit0, 1'b1);
      chk("R6", "strobe one cycle only", w24_eos_strobe, 1'b0);
      chk("R3", "eos_lvl3 after strobe", eos_lvl3, 1'b1);
      drive(5'd24, 4'd1);
      tick();
      chk("R7", "bit0 clears at bit 1", w24_bit0, 1'b0);
      chk("R4", "w24 still set", w24_flag, 1'b1);
   endtask

   // R8: word changes ignored without end-of-scan, then R4 clear
   task automatic t_hold();
      for (int k = 0; k < 4; k++) begin
         drive(5'(k * 7), 4'd5);
         tick();
         chk("R8", "w24 held", w24_flag, 1'b1);
      end
      drive(5'd23, 4'd6);
      tick();
      chk("R8", "word 23 mid-scan no strobe", w24_eos_strobe, 1'b0);
      drive(5'd24, 4'd15);
      tick();
      chk("R6", "no strobe at end of word 24", w24_eos_strobe, 1'b0);
      drive(5'd25, 4'd0);
      tick();
      chk("R4", "w24 cleared", w24_flag, 1'b0);
      chk("R7", "no bit0 outside word 24", w24_bit0, 1'b0);
   endtask

   // R5: near-miss word counts never match
   task automatic t_near_miss();
      logic [4:0] miss [6] = '{5'd7, 5'd15, 5'd19, 5'd21, 5'd22, 5'd31};
      for (int k = 0; k < 6; k++) begin
         drive(miss[k], 4'd15);
         tick();
         chk("R5", "strobe near miss", w24_eos_strobe, 1'b0);
         drive(miss[k], 4'd0);
         tick();
         chk("R5", "w24 near miss", w24_flag, 1'b0);
         chk("R7", "bit0 near miss", w24_bit0, 1'b0);
      end
   endtask

   // R1: reset while word 24 flag is set
   task automatic t_mid_reset();
      drive(5'd23, 4'd15);
      tick();
      drive(5'd24, 4'd0);
      tick();
      chk("R4", "w24 set before reset", w24_flag, 1'b1);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk_all_zero("R1");
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      t_reset();
      t_stagger();
      t_enter_w24();
      t_hold();
      t_near_miss();
      t_mid_reset();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule